// File: doc/BRIEF.md
# PFC Controller Mode Sequencer

This block is the supervisory state machine of a boost power-factor-correction controller. It reads eleven single-bit flags, each the already-synchronized output of an analog comparator or of the soft-start logic. From them it decides which of six operating modes the controller is in. From that mode it drives the gate-drive enable, the oscillator enable, the internal bias enable and a request to discharge the voltage-loop compensation node.

The modes form a ladder. At the bottom is a low-power lockout/sleep mode. Above it is a biased stand-by mode, then the two switching modes (soft-start and normal), and two fault modes that pause switching (overvoltage and peak current). Each transition has its own entry and exit condition. The supply uses separate turn-on and lockout flags. The line sense uses a higher enable level and a lower brown-out level. The open-loop check has a single level. The overvoltage fault is entered on a trip flag and left only on a separate clear flag. A pre-charged compensation node blocks a start. When several conditions hold in one cycle, the higher rung of the ladder wins.

Two parameters choose variants:
- `RESUME_TO_ORIGIN` selects whether a cleared fault returns to the switching mode it interrupted or always to normal.
- `DISCHARGE_BEFORE_SLEEP` selects whether a sleep request from a running mode first waits in stand-by until the compensation node is discharged.

Top module: `pfc_mode_seq`

## Requirements
- R1: While reset is asserted and after its release, the machine is in sleep mode. Mode encoding: sleep=0, stand-by=1, soft-start=2, normal=3, overvoltage fault=4, peak-current fault=5.
- R2: From any mode other than sleep, a sleep request (`vcc_low_i` or `en_sleep_i` high) moves to sleep at the next edge if `comp_low_i` is high. Otherwise it moves to stand-by, where the machine waits with the discharge request raised.
- R3: Sleep is left only when `vcc_on_i` is high and `en_sleep_i` is low, and the exit always goes to stand-by.
- R4: From soft-start, normal or either fault mode, `fb_open_i` or `line_low_i` moves to stand-by.
- R5: Stand-by moves to soft-start only when `fb_open_i` is low, `line_low_i` is low, `line_ok_i` is high and `comp_low_i` is high. A low `comp_low_i` (pre-charged compensation node) blocks the start.
- R6: Soft-start moves to normal when `ss_done_i` is high and no higher-priority condition holds.
- R7: From soft-start, normal or peak-current fault, `ovp_trip_i` enters the overvoltage fault. This fault is left only when `ovp_clear_i` is high. The exit goes to the switching mode that was interrupted.
- R8: From soft-start or normal, `isns_pk_i` enters the peak-current fault. This fault returns to the interrupted switching mode in the first cycle that `isns_pk_i` is low.
- R9: Priority within one cycle, highest first: sleep request, stand-by request, overvoltage trip, peak current, soft-start completion.
- R10: `gate_en_o` is high only in soft-start and normal. `osc_en_o` is high in soft-start, normal and both fault modes. `bias_en_o` is high in every mode except sleep.
- R11: `comp_dis_o` is high only in stand-by. It rises when stand-by is entered from a running mode with `comp_low_i` low, stays high until `comp_low_i` is seen high, and is never raised when stand-by is entered from sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_low_i | input | 1 | Supply below lockout level |
| en_sleep_i | input | 1 | Enable pin below sleep level |
| fb_open_i | input | 1 | Feedback below open-loop level |
| line_ok_i | input | 1 | Line sense above enable level |
| line_low_i | input | 1 | Line sense below brown-out level |
| ovp_trip_i | input | 1 | Either overvoltage sense above trip level |
| ovp_clear_i | input | 1 | Both overvoltage senses below reset level |
| isns_pk_i | input | 1 | Current-sense magnitude above peak level |
| comp_low_i | input | 1 | Compensation voltage below start level |
| ss_done_i | input | 1 | Compensation capacitor fully charged |
| mode_o | output | 3 | Current mode (encoding in R1) |
| gate_en_o | output | 1 | Gate drive enable |
| osc_en_o | output | 1 | Oscillator enable |
| bias_en_o | output | 1 | Internal bias enable |
| comp_dis_o | output | 1 | Compensation discharge request |

## Verification
A directed walk climbs the ladder one rung at a time. Along the way it holds single blocking conditions, such as a pre-charged compensation node, an open feedback or a line sense only between its two levels, to show that each gate on a transition is needed on its own. It then applies combined conditions to separate the priority order: overvoltage trip against peak current, and brown-out against overvoltage. A discharge-then-sleep sequence tells a sleep request with a charged node apart from one with a discharged node. Biased random flags follow. They keep disruptive conditions rare, so that long runs reach the fault modes and their resume targets, and every cycle is compared with a reference model written from the requirements.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      M_SLEEP = 3'd0,
      M_STBY  = 3'd1,
      M_SOFT  = 3'd2,
      M_NORM  = 3'd3,
      M_OVP   = 3'd4,
      M_IPK   = 3'd5
   } pfc_mode_e;

   typedef struct packed {
      logic vcc_on;
      logic vcc_low;
      logic en_sleep;
      logic fb_open;
      logic line_ok;
      logic line_low;
      logic ovp_trip;
      logic ovp_clear;
      logic isns_pk;
      logic comp_low;
      logic ss_done;
   } pfc_flags_t;

   function automatic logic is_running(pfc_mode_e m);
      return (m == M_SOFT) || (m == M_NORM) || (m == M_OVP) || (m == M_IPK);
   endfunction

   function automatic logic is_switching(pfc_mode_e m);
      return (m == M_SOFT) || (m == M_NORM);
   endfunction

endpackage

// File: rtl/pfc_seq_next.sv
module pfc_seq_next
   import pfc_seq_pkg::*;
#(
   parameter int RESUME_TO_ORIGIN       = 1,
   parameter int DISCHARGE_BEFORE_SLEEP = 1
) (
   input  pfc_mode_e  cur_i,
   input  pfc_mode_e  res_i,
   input  logic       dis_i,
   input  pfc_flags_t fl_i,
   output pfc_mode_e  nxt_o,
   output pfc_mode_e  res_o,
   output logic       dis_o
);

   if (RESUME_TO_ORIGIN < 0 || RESUME_TO_ORIGIN > 1) begin : g_bad_resume
      $error("RESUME_TO_ORIGIN must be 0 or 1");
   end
   if (DISCHARGE_BEFORE_SLEEP < 0 || DISCHARGE_BEFORE_SLEEP > 1) begin : g_bad_dis
      $error("DISCHARGE_BEFORE_SLEEP must be 0 or 1");
   end

   logic      sleep_req;
   logic      stby_req;
   logic      start_ok;
   logic      wake_ok;
   pfc_mode_e back_mode;
   pfc_mode_e sleep_dst;

   assign sleep_req = fl_i.vcc_low | fl_i.en_sleep;
   assign stby_req  = fl_i.fb_open | fl_i.line_low;
   assign start_ok  = ~fl_i.fb_open & ~fl_i.line_low & fl_i.line_ok & fl_i.comp_low;
   assign wake_ok   = fl_i.vcc_on & ~fl_i.en_sleep;

   // Where a cleared fault returns to
   if (RESUME_TO_ORIGIN == 1) begin : g_back_origin
      assign back_mode = res_i;
   end else begin : g_back_norm
      assign back_mode = M_NORM;
   end

   // Where a sleep request goes first
   if (DISCHARGE_BEFORE_SLEEP == 1) begin : g_sleep_wait
      assign sleep_dst = fl_i.comp_low ? M_SLEEP : M_STBY;
   end else begin : g_sleep_direct
      assign sleep_dst = M_SLEEP;
   end

   always_comb begin
      nxt_o = cur_i;
      case (cur_i)
         M_SLEEP: begin
            if (wake_ok) nxt_o = M_STBY;
         end
         M_STBY: begin
            if (sleep_req)     nxt_o = sleep_dst;
            else if (start_ok) nxt_o = M_SOFT;
         end
         M_OVP: begin
            if (sleep_req)           nxt_o = sleep_dst;
            else if (stby_req)       nxt_o = M_STBY;
            else if (fl_i.ovp_clear) nxt_o = back_mode;
         end
         M_IPK: begin
            if (sleep_req)          nxt_o = sleep_dst;
            else if (stby_req)      nxt_o = M_STBY;
            else if (fl_i.ovp_trip) nxt_o = M_OVP;
            else if (!fl_i.isns_pk) nxt_o = back_mode;
         end
         M_SOFT, M_NORM: begin
            if (sleep_req)          nxt_o = sleep_dst;
            else if (stby_req)      nxt_o = M_STBY;
            else if (fl_i.ovp_trip) nxt_o = M_OVP;
            else if (fl_i.isns_pk)  nxt_o = M_IPK;
            else if (cur_i == M_SOFT && fl_i.ss_done) nxt_o = M_NORM;
         end
         default: nxt_o = M_SLEEP;
      endcase
   end

   assign res_o = is_switching(cur_i) ? cur_i : res_i;
   assign dis_o = (nxt_o == M_STBY) & ~fl_i.comp_low & (is_running(cur_i) | dis_i);

endmodule

// File: rtl/pfc_seq_out.sv
module pfc_seq_out
   import pfc_seq_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  pfc_mode_e mode_i,
   output logic      gate_en_o,
   output logic      osc_en_o,
   output logic      bias_en_o
);

   always_comb begin
      gate_en_o = 1'b0;
      osc_en_o  = 1'b0;
      bias_en_o = 1'b1;
      case (mode_i)
         M_SLEEP:        bias_en_o = 1'b0;
         M_SOFT, M_NORM: begin
            gate_en_o = 1'b1;
            osc_en_o  = 1'b1;
         end
         M_OVP, M_IPK:   osc_en_o = 1'b1;
         default:        ;
      endcase
   end

   // R10: switching needs the oscillator, the oscillator needs bias
   a_r10_gate_needs_osc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gate_en_o |-> osc_en_o);
   a_r10_osc_needs_bias: assert property (@(posedge clk_i) disable iff (!rst_ni)
      osc_en_o |-> bias_en_o);

endmodule

// File: rtl/pfc_mode_seq.sv
module pfc_mode_seq
   import pfc_seq_pkg::*;
#(
   parameter int RESUME_TO_ORIGIN       = 1,
   parameter int DISCHARGE_BEFORE_SLEEP = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              vcc_on_i,
   input  logic              vcc_low_i,
   input  logic              en_sleep_i,
   input  logic              fb_open_i,
   input  logic              line_ok_i,
   input  logic              line_low_i,
   input  logic              ovp_trip_i,
   input  logic              ovp_clear_i,
   input  logic              isns_pk_i,
   input  logic              comp_low_i,
   input  logic              ss_done_i,
   output logic [MODE_W-1:0] mode_o,
   output logic              gate_en_o,
   output logic              osc_en_o,
   output logic              bias_en_o,
   output logic              comp_dis_o
);

   pfc_flags_t fl;
   pfc_mode_e  mode_q, mode_d;
   pfc_mode_e  res_q, res_d;
   logic       dis_q, dis_d;

   assign fl = '{vcc_on:    vcc_on_i,    vcc_low:  vcc_low_i,
                 en_sleep:  en_sleep_i,  fb_open:  fb_open_i,
                 line_ok:   line_ok_i,   line_low: line_low_i,
                 ovp_trip:  ovp_trip_i,  ovp_clear: ovp_clear_i,
                 isns_pk:   isns_pk_i,   comp_low: comp_low_i,
                 ss_done:   ss_done_i};

   pfc_seq_next #(
      .RESUME_TO_ORIGIN      (RESUME_TO_ORIGIN),
      .DISCHARGE_BEFORE_SLEEP(DISCHARGE_BEFORE_SLEEP)
   ) next_i (
      .cur_i (mode_q),
      .res_i (res_q),
      .dis_i (dis_q),
      .fl_i  (fl),
      .nxt_o (mode_d),
      .res_o (res_d),
      .dis_o (dis_d)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q <= M_SLEEP;
         res_q  <= M_SOFT;
         dis_q  <= 1'b0;
      end else begin
         mode_q <= mode_d;
         res_q  <= res_d;
         dis_q  <= dis_d;
      end
   end

   pfc_seq_out out_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (mode_q),
      .gate_en_o (gate_en_o),
      .osc_en_o  (osc_en_o),
      .bias_en_o (bias_en_o)
   );

   assign mode_o     = mode_q;
   assign comp_dis_o = dis_q;

   a_r2_sleep_when_discharged: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q != M_SLEEP && (vcc_low_i || en_sleep_i) && comp_low_i) |=> mode_q == M_SLEEP);

   a_r3_hold_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == M_SLEEP && !(vcc_on_i && !en_sleep_i)) |=> mode_q == M_SLEEP);

   a_r5_prebias_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == M_STBY && !comp_low_i) |=> mode_q != M_SOFT);

   a_r7_ovp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == M_OVP && !ovp_clear_i && !vcc_low_i && !en_sleep_i
       && !fb_open_i && !line_low_i) |=> mode_q == M_OVP);

   a_r11_dis_in_stby: assert property (@(posedge clk_i) disable iff (!rst_ni)
      comp_dis_o |-> mode_q == M_STBY);

   a_r11_no_dis_on_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == M_SLEEP) |=> !comp_dis_o);

endmodule

// File: tb/pfc_mode_seq_tb_top.sv
`timescale 1ns/100ps
module pfc_mode_seq_tb_top;
   import pfc_seq_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   pfc_flags_t f;
   logic [2:0] mode_o;
   logic gate_en_o, osc_en_o, bias_en_o, comp_dis_o;

   pfc_mode_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .vcc_on_i(f.vcc_on), .vcc_low_i(f.vcc_low), .en_sleep_i(f.en_sleep),
      .fb_open_i(f.fb_open), .line_ok_i(f.line_ok), .line_low_i(f.line_low),
      .ovp_trip_i(f.ovp_trip), .ovp_clear_i(f.ovp_clear), .isns_pk_i(f.isns_pk),
      .comp_low_i(f.comp_low), .ss_done_i(f.ss_done),
      .mode_o(mode_o), .gate_en_o(gate_en_o), .osc_en_o(osc_en_o),
      .bias_en_o(bias_en_o), .comp_dis_o(comp_dis_o));

   int checks = 0;
   int errors = 0;
   logic [2:0] e_mode = 3'd0;
   logic [2:0] e_res  = 3'd2;
   logic       e_dis  = 1'b0;

   // Reference model written from the requirements
   function automatic logic [2:0] model_next(logic [2:0] m, logic [2:0] r, pfc_flags_t x);
      logic sreq, breq;
      sreq = x.vcc_low | x.en_sleep;
      breq = x.fb_open | x.line_low;
      if (m == 3'd0) return (x.vcc_on && !x.en_sleep) ? 3'd1 : 3'd0;
      if (sreq) return x.comp_low ? 3'd0 : 3'd1;
      if (m == 3'd1)
         return (!x.fb_open && !x.line_low && x.line_ok && x.comp_low) ? 3'd2 : 3'd1;
      if (breq) return 3'd1;
      if (m == 3'd4) return x.ovp_clear ? r : 3'd4;
      if (x.ovp_trip) return 3'd4;
      if (m == 3'd5) return x.isns_pk ? 3'd5 : r;
      if (x.isns_pk) return 3'd5;
      if (m == 3'd2 && x.ss_done) return 3'd3;
      return m;
   endfunction

   task automatic compare(string tag);
      logic eg, eo, eb;
      eg = (e_mode == 3'd2) || (e_mode == 3'd3);
      eo = eg || (e_mode == 3'd4) || (e_mode == 3'd5);
      eb = (e_mode != 3'd0);
      checks++;
      if (mode_o !== e_mode || gate_en_o !== eg || osc_en_o !== eo ||
          bias_en_o !== eb || comp_dis_o !== e_dis) begin
         errors++;
         $display("FAIL %s: mode/gate/osc/bias/dis actual %0d/%b/%b/%b/%b expected %0d/%b/%b/%b/%b",
                  tag, mode_o, gate_en_o, osc_en_o, bias_en_o, comp_dis_o,
                  e_mode, eg, eo, eb, e_dis);
      end
   endtask

   // Called just after a falling edge with f already set
   task automatic step(string tag);
      logic [2:0] nm;
      nm = model_next(e_mode, e_res, f);
      e_dis = (nm == 3'd1) && !f.comp_low &&
              ((e_mode >= 3'd2 && e_mode <= 3'd5) || e_dis);
      if (e_mode == 3'd2 || e_mode == 3'd3) e_res = e_mode;
      e_mode = nm;
      @(posedge clk);
      #1;
      compare(tag);
      @(negedge clk);
   endtask

   function automatic logic pick(int pct);
      return ($urandom % 100) < pct;
   endfunction

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      f = '0;
      f.comp_low = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      compare("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      step("R1 after release");

      f.vcc_on = 1'b1; f.en_sleep = 1'b1;  step("R3 enable pin still low");
      f.en_sleep = 1'b0;                   step("R3 wake to stand-by, R11 no discharge");
      f.comp_low = 1'b0; f.line_ok = 1'b1; step("R5 pre-biased node blocks start");
      f.comp_low = 1'b1; f.fb_open = 1'b1; step("R5 open feedback blocks start");
      f.fb_open = 1'b0; f.line_ok = 1'b0;  step("R5 line between levels blocks start");
      f.line_ok = 1'b1;                    step("R5 start, R10 gate on");
      f.ss_done = 1'b1;                    step("R6 soft-start to normal");
      f.ovp_trip = 1'b1; f.isns_pk = 1'b1; step("R9 overvoltage over peak current");
      f.ovp_trip = 1'b0;                   step("R7 hold fault until clear, R10 osc only");
      f.ovp_clear = 1'b1; f.isns_pk = 1'b0; step("R7 resume normal");
      f.ovp_clear = 1'b0; f.isns_pk = 1'b1; step("R8 peak current fault");
      f.isns_pk = 1'b0;                    step("R8 resume normal");
      f.comp_low = 1'b0; f.line_low = 1'b1; f.ovp_trip = 1'b1;
      step("R4 R9 brown-out over overvoltage, R11 discharge raised");
      f.line_low = 1'b0; f.ovp_trip = 1'b0; f.en_sleep = 1'b1;
      step("R2 sleep waits for discharge, R11 held");
      f.comp_low = 1'b1;                   step("R2 sleep after discharge");
      f.en_sleep = 1'b0; f.ss_done = 1'b0; step("R3 wake again");
      step("R5 start again");
      f.ovp_trip = 1'b1;                   step("R7 fault from soft-start");
      f.ovp_trip = 1'b0; f.ovp_clear = 1'b1; step("R7 resume soft-start");
      f.ovp_clear = 1'b0; f.fb_open = 1'b1; step("R4 open loop from soft-start");

      for (int i = 0; i < 6000; i++) begin
         f.vcc_on    = pick(92);
         f.vcc_low   = pick(2);
         f.en_sleep  = pick(2);
         f.fb_open   = pick(4);
         f.line_ok   = pick(85);
         f.line_low  = pick(4);
         f.ovp_trip  = pick(8);
         f.ovp_clear = pick(45);
         f.isns_pk   = pick(12);
         f.comp_low  = pick(65);
         f.ss_done   = pick(25);
         step("R9 random mix");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule